// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog timer with two clock domains. Registers are written and read on a bus clock. Counting runs on a separate oscillator clock. To arm it, software writes a 12-bit period, clears the elapsed count and sets the enable bit. While enabled, the counter advances one unit every 2^PRE_BITS oscillator cycles, where PRE_BITS is 20 by default. When the count passes the programmed period, an overflow occurs.

The first overflow raises the interrupt line. If a second overflow follows it with no refresh in between, the reset output is asserted and stays asserted until the block's own asynchronous reset is applied. Software refreshes the watchdog by writing 1 to bit 0 of the refresh register. Software can also request an immediate reset by forcing an error through a dedicated register, but only while the error-mode register selects reset-on-error.

Each bus write event is carried into the oscillator domain through its own toggle synchronizer. A single write therefore takes effect exactly once, after a few oscillator cycles.

Top module: `twoStrikeWdt`

## Requirements
- R1: After the asynchronous reset, the interrupt and reset outputs are 0, and every register reads 0.
- R2: The period is held in bits [31:20] of the register at offset 0x04. Bits [19:0] of that register always read 0, whatever was written to them.
- R3: With enable set (bit 0 at offset 0x00) and period N, the first overflow comes (N+1)*2^PRE_BITS oscillator cycles after counting starts, and it raises the interrupt.
- R4: A second overflow with no refresh since the first asserts the reset output.
- R5: Writing a value with bit 0 set to offset 0x0C clears the count, the pending interrupt and the first-overflow state. The next overflow after this write only raises the interrupt again.
- R6: Any write to offset 0x08 restarts the count from zero. While enable is 0, the count is held at zero and no overflow occurs.
- R7: A write to the period register while enable reads 1 is ignored.
- R8: Writing a value with bit 0 set to offset 0x14 asserts the reset output when bit 0 of offset 0x10 is 0. The same write has no effect when bit 0 of offset 0x10 is 1.
- R9: Once asserted, the reset output stays at 1 through refreshes and disabling, and clears only on the asynchronous reset.
- R10: Bit 0 of offset 0x00 reads back the enable value written to it. Bit 0 of offset 0x10 reads back the error mode written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register access clock |
| oscClk | input | 1 | Counting clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWe | input | 1 | Write strobe, one bus cycle per write |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | First-overflow interrupt |
| wdtRstOut | output | 1 | Sticky reset request |

## Verification
The assertions assume that the register values software writes stay put until the oscillator domain has captured them. They also assume that two writes of the same kind are never closer together than the synchronizer latency. The bench keeps to both assumptions: every write is followed by a wait of several oscillator cycles before the next one. Periods are drawn at random from a small range, and each timing check leaves a margin of a few oscillator cycles on either side of the computed overflow time, so that the synchronizer delay cannot move an edge across a sample point.

// File: rtl/wdtPkg.sv
package wdtPkg;
  localparam int PERIOD_W = 12;

  // Oscillator-domain view of the register file handed to the datapath
  typedef struct packed {
    logic                enable;
    logic [PERIOD_W-1:0] period;
    logic                cntLoad;
    logic                kick;
    logic                forceRst;
  } wdtStrobeT;
endpackage

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import wdtPkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic              busClk,
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output wdtStrobeT         strobe
);
  localparam int N_EVT = 4;
  localparam int PLO   = DATA_W - PERIOD_W;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ELAP  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(8'h14);

  logic                enReg, modeReg;
  logic [PERIOD_W-1:0] periodReg;
  logic [N_EVT-1:0]    evtHit, togReg, pulseReg;

  // event order: 0 config, 1 count load, 2 refresh, 3 forced error
  assign evtHit[0] = busWe && (busAddr == A_CTRL);
  assign evtHit[1] = busWe && (busAddr == A_ELAP);
  assign evtHit[2] = busWe && (busAddr == A_KICK) && busWdata[0];
  assign evtHit[3] = busWe && (busAddr == A_FORCE) && busWdata[0] && !modeReg;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      modeReg   <= 1'b0;
      periodReg <= '0;
      togReg    <= '0;
    end else begin
      togReg <= togReg ^ evtHit;
      if (busWe && busAddr == A_CTRL) enReg <= busWdata[0];
      if (busWe && busAddr == A_PER && !enReg) periodReg <= busWdata[DATA_W-1:PLO];
      if (busWe && busAddr == A_MODE) modeReg <= busWdata[0];
    end
  end

  assert_period_lock_R7: assert property (@(posedge busClk) disable iff (!rstN)
    (enReg && $past(enReg)) |-> $stable(periodReg));

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL: busRdata[0] = enReg;
      A_PER:  busRdata[DATA_W-1:PLO] = periodReg;
      A_MODE: busRdata[0] = modeReg;
      default: busRdata = '0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_EVT; gi++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge oscClk or negedge rstN) begin
        if (!rstN) begin
          chain        <= '0;
          pulseReg[gi] <= 1'b0;
        end else begin
          chain        <= {chain[SYNC_STAGES-2:0], togReg[gi]};
          pulseReg[gi] <= chain[SYNC_STAGES-1] ^ chain[SYNC_STAGES-2];
        end
      end
    end
  endgenerate

  logic                oscEn;
  logic [PERIOD_W-1:0] oscPer;
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      oscEn  <= 1'b0;
      oscPer <= '0;
    end else if (pulseReg[0]) begin
      oscEn <= enReg;
      if (!oscEn) oscPer <= periodReg;
    end
  end

  assign strobe.enable   = oscEn;
  assign strobe.period   = oscPer;
  assign strobe.cntLoad  = pulseReg[1];
  assign strobe.kick     = pulseReg[2];
  assign strobe.forceRst = pulseReg[3];
endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int PRE_BITS = 20
) (
  input  logic      oscClk,
  input  logic      rstN,
  input  wdtStrobeT strobe,
  output logic      irqOut,
  output logic      rstOut
);
  logic [PRE_BITS-1:0] preCnt;
  logic [PERIOD_W-1:0] unitCnt;
  logic                strike, irqReg, rstHit, rstQ;
  logic                wrapNow;

  assign wrapNow = strobe.enable && (&preCnt) && (unitCnt == strobe.period);

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      unitCnt <= '0;
      strike  <= 1'b0;
      irqReg  <= 1'b0;
      rstHit  <= 1'b0;
      rstQ    <= 1'b0;
    end else begin
      rstQ <= rstHit;
      if (strobe.forceRst) rstHit <= 1'b1;
      if (strobe.kick) begin
        irqReg <= 1'b0;
        strike <= 1'b0;
      end
      if (!strobe.enable) begin
        preCnt  <= '0;
        unitCnt <= '0;
        strike  <= 1'b0;
      end else if (strobe.kick || strobe.cntLoad) begin
        preCnt  <= '0;
        unitCnt <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
        if (&preCnt) unitCnt <= wrapNow ? '0 : unitCnt + 1'b1;
        if (wrapNow) begin
          if (strike) rstHit <= 1'b1;
          else begin
            strike <= 1'b1;
            irqReg <= 1'b1;
          end
        end
      end
    end
  end

  assign irqOut = irqReg;
  assign rstOut = rstQ;

  assert_hold_zero_R6: assert property (@(posedge oscClk) disable iff (!rstN)
    !strobe.enable |=> (preCnt == '0 && unitCnt == '0));
  assert_irq_on_wrap_R3: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(irqReg) |-> $past(wrapNow));
  assert_second_wrap_R4: assert property (@(posedge oscClk) disable iff (!rstN)
    $rose(rstHit) |-> ($past(strobe.forceRst) || ($past(wrapNow) && $past(strike))));
  assert_sticky_R9: assert property (@(posedge oscClk) disable iff (!rstN)
    rstHit |=> rstHit);
  assert_kick_clears_R5: assert property (@(posedge oscClk) disable iff (!rstN)
    strobe.kick |=> (!irqReg && !strike));
endmodule

// File: rtl/twoStrikeWdt.sv
module twoStrikeWdt
  import wdtPkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int PRE_BITS = 20
) (
  input  logic              busClk,
  input  logic              oscClk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              wdtRstOut
);
  wdtStrobeT strobe;

  wdtCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(3)) uCtrl (
    .busClk(busClk), .oscClk(oscClk), .rstN(rstN), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .strobe(strobe)
  );

  wdtDatapath #(.PRE_BITS(PRE_BITS)) uDp (
    .oscClk(oscClk), .rstN(rstN), .strobe(strobe),
    .irqOut(irqOut), .rstOut(wdtRstOut)
  );
endmodule

// File: tb/sim_twoStrikeWdt.sv
module sim_twoStrikeWdt;
  localparam int PRE = 4;
  logic busClk = 1'b0, oscClk = 1'b0, rstN = 1'b0, busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irqOut, wdtRstOut;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 busClk = ~busClk;
  always #6 oscClk = ~oscClk;

  twoStrikeWdt #(.PRE_BITS(PRE)) u0 (
    .busClk(busClk), .oscClk(oscClk), .rstN(rstN), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .wdtRstOut(wdtRstOut)
  );

  function automatic int cycLen(int n);
    return (n + 1) << PRE;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitOsc(int n);
    repeat (n) @(posedge oscClk);
    #2;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge busClk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitOsc(3);
    rstN = 1'b1;
    waitOsc(2);
  endtask

  task automatic arm(int n);
    wr(5'h04, 32'(n) << 20);
    waitOsc(6);
    wr(5'h08, 32'h0);
    waitOsc(6);
    wr(5'h00, 32'h1);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog timeout");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, len;
    void'($urandom(32'd11));
    doReset();
    check("R1 irq", 32'(irqOut), 0);
    check("R1 rst", 32'(wdtRstOut), 0);
    rd(5'h00, v); check("R1 ctrl", v, 0);
    rd(5'h04, v); check("R1 period", v, 0);
    rd(5'h10, v); check("R1 mode", v, 0);

    // R2: low bits read zero
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); check("R2 period mask", v, 32'hFFF0_0000);

    // R3 / R4 with random periods
    for (int it = 0; it < 4; it++) begin
      doReset();
      n = 1 + int'($urandom % 12);
      len = cycLen(n);
      arm(n);
      rd(5'h00, v); check("R10 enable read", v, 1);
      waitOsc(len - 2);  check("R3 no irq early", 32'(irqOut), 0);
      waitOsc(10);       check("R3 irq at overflow", 32'(irqOut), 1);
      check("R4 no rst after first", 32'(wdtRstOut), 0);
      waitOsc(len - 12); check("R4 no rst early", 32'(wdtRstOut), 0);
      waitOsc(12);       check("R4 rst at second", 32'(wdtRstOut), 1);
      // R9: sticky through refresh and disable
      wr(5'h0C, 32'h1); waitOsc(6);
      wr(5'h00, 32'h0); waitOsc(8);
      check("R9 rst sticky", 32'(wdtRstOut), 1);
    end
    doReset();
    check("R9 rst cleared by reset", 32'(wdtRstOut), 0);

    // R5: periodic refresh keeps quiet
    n = 5; len = cycLen(n);
    arm(n);
    for (int k = 0; k < 6; k++) begin
      waitOsc(len / 2);
      wr(5'h0C, 32'h1);
    end
    waitOsc(8);
    check("R5 periodic refresh no irq", 32'(irqOut), 0);
    check("R5 periodic refresh no rst", 32'(wdtRstOut), 0);
    // refresh with bit0 clear is not a refresh: counting continues
    wr(5'h0C, 32'h0);
    waitOsc(len + 8);
    check("R5 bit0 clear no refresh", 32'(irqOut), 1);
    wr(5'h0C, 32'h1);
    waitOsc(8);
    check("R5 refresh clears irq", 32'(irqOut), 0);
    waitOsc(len);
    check("R5 next overflow irq", 32'(irqOut), 1);
    check("R5 next overflow no rst", 32'(wdtRstOut), 0);

    // R7: period locked while enabled
    wr(5'h04, 32'h0010_0000);
    rd(5'h04, v); check("R7 period locked", v, 32'(n) << 20);

    // R6: count restart and disabled hold
    doReset();
    n = 4; len = cycLen(n);
    arm(n);
    waitOsc(len / 2);
    wr(5'h08, 32'h0);
    waitOsc(len - 4); check("R6 restart delays irq", 32'(irqOut), 0);
    waitOsc(14);      check("R6 irq after restart", 32'(irqOut), 1);
    doReset();
    wr(5'h04, 32'h1 << 20);
    waitOsc(3 * cycLen(1));
    check("R6 disabled no irq", 32'(irqOut), 0);

    // R8: forced error
    doReset();
    wr(5'h10, 32'h1);
    rd(5'h10, v); check("R10 mode read", v, 1);
    wr(5'h14, 32'h1); waitOsc(10);
    check("R8 force ignored in mode 1", 32'(wdtRstOut), 0);
    wr(5'h10, 32'h0); waitOsc(4);
    wr(5'h14, 32'h1); waitOsc(10);
    check("R8 force resets in mode 0", 32'(wdtRstOut), 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule